// File: doc/BRIEF.md
# Slot-Ordered Sample Readout Buffer

This block lets a host or DMA engine pull per-sample results from four synchronised processing channels through a single read address. Each channel supplies a 24-bit I value, a 24-bit Q value, a 24-bit magnitude, a 16-bit phase and a 16-bit gain word. A sample-ready pulse freezes a snapshot of all channels. The host then reads 16-bit words one after another from data address 2, with no writes in between.

The order of the words is set by a table of 32 slots that the host programs. Each slot names a channel and one of eight word kinds. The sequence runs up to the first slot marked invalid. A status word at address 3 reports fresh data, and it also reports an overrun when a new sample-ready pulse cuts a read sequence short. All channels share one snapshot and one read pointer, so the channels must produce their samples on the same pulse.

Top module: `slot_readout_buffer`

## Requirements
- R1: The word kind code is a 3-bit field. Its values are: 0 = I[23:8], 1 = {I[7:0], 8'h00}, 2 = Q[23:8], 3 = {Q[7:0], 8'h00}, 4 = magnitude[23:8], 5 = {magnitude[7:0], 8'h00}, 6 = phase[15:0], 7 = gain[15:0]. Each word is taken from the channel that the slot names.
- R2: The upper I and Q words are plain truncations. Bits 7:0 have no effect on them, even when bit 7 is set.
- R3: A table write stores `tbl_entry` in slot `tbl_idx`. The entry fields are bit 5 = valid, bits 4:3 = channel, bits 2:0 = word kind. Reset clears every slot to invalid.
- R4: A read at address 2 of a valid slot returns that slot's word and moves the pointer to the next slot. Back-to-back reads need no write between them.
- R5: The sequence ends at the first invalid slot, or after slot 31. A data read past the end returns 0 and leaves the pointer where it is.
- R6: A sample-ready pulse captures every channel's inputs and returns the pointer to slot 0. Reads after the pulse return the new snapshot, in table order.
- R7: A read at address 3 returns bit 0 = new data and bit 1 = overrun, with all other bits 0. A pulse sets new data when slot 0 is valid and clears it otherwise. Reading the last valid slot clears new data.
- R8: A pulse that arrives while new data is set and at least one word of the sequence has been read sets overrun. A status read clears overrun unless that same cycle sets it.
- R9: `host_rdata` changes only on the clock edge that follows a read strobe, and then holds. A read at any address other than 2 or 3 returns 0.
- R10: When a data read and a pulse fall in the same cycle, the pulse wins. The read returns 0 and the pointer goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_i | input | 96 | I values, 24 bits per channel, channel 0 in the low bits |
| ch_q | input | 96 | Q values, 24 bits per channel |
| ch_mag | input | 96 | Magnitude values, 24 bits per channel |
| ch_phase | input | 64 | Phase values, 16 bits per channel |
| ch_agc | input | 64 | Gain values, 16 bits per channel |
| sample_irq | input | 1 | Sample-ready pulse that captures the channels and restarts the sequence |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host direct address (2 = data, 3 = status) |
| host_rdata | output | 16 | Registered read response |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_idx | input | 5 | Slot number to write |
| tbl_entry | input | 6 | Slot contents {valid, channel[1:0], kind[2:0]} |

## Verification
The hardest situations to reach are the ones where a sample-ready pulse cuts into a sequence the host has already started. The overrun flag needs a pulse after at least one word has been read but before the last one. The collision rule needs the pulse and a data read in the very same cycle. The stimulus reaches both on purpose: it reads a few words of a sequence, then fires a second pulse, and in a separate pass it raises the read strobe and the pulse on one clock. After each of these, it reads status and then the whole new sequence, which shows the restarted pointer and the fresh snapshot.

// File: rtl/rdo_pkg.sv
// Package: shared types and the word-formatting function for the readout buffer.
// Assumes at most four channels, because the slot entry carries a 2-bit channel field.
package rdo_pkg;

    localparam int SMP_W  = 24;
    localparam int AUX_W  = 16;
    localparam int WORD_W = 16;
    localparam logic [2:0] ADDR_DATA = 3'd2;
    localparam logic [2:0] ADDR_STAT = 3'd3;

    typedef enum logic [2:0] {
        K_I_HI = 3'd0, K_I_LO = 3'd1, K_Q_HI = 3'd2, K_Q_LO = 3'd3,
        K_M_HI = 3'd4, K_M_LO = 3'd5, K_PHASE = 3'd6, K_GAIN = 3'd7
    } word_kind_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] chan;
        word_kind_e kind;
    } slot_t;

    typedef struct packed {
        logic [SMP_W-1:0] i;
        logic [SMP_W-1:0] q;
        logic [SMP_W-1:0] mag;
        logic [AUX_W-1:0] ph;
        logic [AUX_W-1:0] gain;
    } chan_sample_t;

    // Select one 16-bit word from a channel sample; upper words are truncated.
    function automatic logic [WORD_W-1:0] pick_word(chan_sample_t s, word_kind_e k);
        case (k)
            K_I_HI:  return s.i[SMP_W-1 -: WORD_W];
            K_I_LO:  return {s.i[7:0], 8'h00};
            K_Q_HI:  return s.q[SMP_W-1 -: WORD_W];
            K_Q_LO:  return {s.q[7:0], 8'h00};
            K_M_HI:  return s.mag[SMP_W-1 -: WORD_W];
            K_M_LO:  return {s.mag[7:0], 8'h00};
            K_PHASE: return s.ph;
            default: return s.gain;
        endcase
    endfunction

endpackage

// File: rtl/rdo_slot_table.sv
// Slot table: SLOTS programmable entries with one write port and two read ports.
// Read port A serves the current slot; read port B looks ahead one slot.
// Assumes the read indices are already limited to the table range by the caller.
module rdo_slot_table
    import rdo_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_entry,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output slot_t            rd_entry_a,
    output slot_t            rd_entry_b,
    output slot_t            first_entry
);

    slot_t tbl [SLOTS];

    // Store host-programmed entries; reset marks every slot invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) tbl[s] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_entry;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_entry_a  = tbl[rd_idx_a];
        rd_entry_b  = tbl[rd_idx_b];
        first_entry = tbl[0];
    end

endmodule

// File: rtl/rdo_snapshot.sv
// Snapshot: captures every channel's flattened inputs on the sample-ready pulse.
// Assumes the inputs are stable in the cycle in which the pulse is high.
module rdo_snapshot
    import rdo_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [NCH*SMP_W-1:0] in_i,
    input  logic [NCH*SMP_W-1:0] in_q,
    input  logic [NCH*SMP_W-1:0] in_mag,
    input  logic [NCH*AUX_W-1:0] in_ph,
    input  logic [NCH*AUX_W-1:0] in_gain,
    output chan_sample_t         snap [NCH]
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Hold one channel's sample until the next capture.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap[c] <= '0;
            end else if (capture) begin
                snap[c].i    <= in_i[c*SMP_W +: SMP_W];
                snap[c].q    <= in_q[c*SMP_W +: SMP_W];
                snap[c].mag  <= in_mag[c*SMP_W +: SMP_W];
                snap[c].ph   <= in_ph[c*AUX_W +: AUX_W];
                snap[c].gain <= in_gain[c*AUX_W +: AUX_W];
            end
        end
    end

endmodule

// File: rtl/rdo_read_ctrl.sv
// Read control: pointer, new-data and overrun flags, and the registered host response.
// Assumes cur_ok and next_ok describe the slot at ptr and the slot after it.
module rdo_read_ctrl
    import rdo_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int PTR_W = $clog2(SLOTS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic              rd,
    input  logic [2:0]        addr,
    input  logic              cur_ok,
    input  logic              next_ok,
    input  logic              first_ok,
    input  logic [WORD_W-1:0] cur_word,
    output logic [PTR_W-1:0]  ptr,
    output logic              new_flag,
    output logic              ovr_flag,
    output logic [WORD_W-1:0] rdata
);

    logic data_rd, stat_rd, advance;

    // Decode the strobe kinds for this cycle.
    always_comb begin
        data_rd = rd && (addr == ADDR_DATA);
        stat_rd = rd && (addr == ADDR_STAT);
        advance = data_rd && cur_ok && !irq;
    end

    // Pointer and flag updates; the pulse takes priority over reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            new_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (irq)          ptr <= '0;
            else if (advance) ptr <= ptr + PTR_W'(1);

            if (irq)                      new_flag <= first_ok;
            else if (advance && !next_ok) new_flag <= 1'b0;

            if (irq && new_flag && (ptr != '0)) ovr_flag <= 1'b1;
            else if (stat_rd)                   ovr_flag <= 1'b0;
        end
    end

    // Registered response, updated only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            if (advance)      rdata <= cur_word;
            else if (stat_rd) rdata <= {{(WORD_W-2){1'b0}}, ovr_flag, new_flag};
            else              rdata <= '0;
        end
    end

endmodule

// File: rtl/slot_readout_buffer.sv
// Top: slot-ordered readout of a shared channel snapshot through one host data address.
// Assumes all channels are synchronised to sample_irq and NCH <= 4.
module slot_readout_buffer
    import rdo_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int SLOTS = 32,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*SMP_W-1:0] ch_i,
    input  logic [NCH*SMP_W-1:0] ch_q,
    input  logic [NCH*SMP_W-1:0] ch_mag,
    input  logic [NCH*AUX_W-1:0] ch_phase,
    input  logic [NCH*AUX_W-1:0] ch_agc,
    input  logic                 sample_irq,
    input  logic                 host_rd,
    input  logic [2:0]           host_addr,
    output logic [WORD_W-1:0]    host_rdata,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_idx,
    input  logic [5:0]           tbl_entry
);

    localparam logic [PTR_W-1:0] SLOTS_P = PTR_W'(SLOTS);

    chan_sample_t      snap [NCH];
    slot_t             cur_e, nxt_e, first_e;
    logic [PTR_W-1:0]  rd_ptr, nxt_ptr;
    logic              cur_ok, next_ok, flag_new, flag_ovr;
    logic [WORD_W-1:0] cur_word;

    // Slot validity around the pointer, bounded to the table range.
    always_comb begin
        nxt_ptr = rd_ptr + PTR_W'(1);
        cur_ok  = (rd_ptr < SLOTS_P) && cur_e.valid;
        next_ok = (nxt_ptr < SLOTS_P) && nxt_e.valid;
    end

    // Format the word of the current slot; an out-of-range channel yields 0.
    always_comb begin
        cur_word = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(cur_e.chan) == c) cur_word = pick_word(snap[c], cur_e.kind);
        end
    end

    rdo_slot_table #(.SLOTS(SLOTS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_we),
        .wr_idx     (tbl_idx),
        .wr_entry   (slot_t'(tbl_entry)),
        .rd_idx_a   (rd_ptr[IDX_W-1:0]),
        .rd_idx_b   (nxt_ptr[IDX_W-1:0]),
        .rd_entry_a (cur_e),
        .rd_entry_b (nxt_e),
        .first_entry(first_e)
    );

    rdo_snapshot #(.NCH(NCH)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(sample_irq),
        .in_i   (ch_i),
        .in_q   (ch_q),
        .in_mag (ch_mag),
        .in_ph  (ch_phase),
        .in_gain(ch_agc),
        .snap   (snap)
    );

    rdo_read_ctrl #(.SLOTS(SLOTS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq     (sample_irq),
        .rd      (host_rd),
        .addr    (host_addr),
        .cur_ok  (cur_ok),
        .next_ok (next_ok),
        .first_ok(first_e.valid),
        .cur_word(cur_word),
        .ptr     (rd_ptr),
        .new_flag(flag_new),
        .ovr_flag(flag_ovr),
        .rdata   (host_rdata)
    );

endmodule

// File: rtl/rdo_checker.sv
// Checker: temporal properties of the readout buffer, bound to the top module.
module rdo_checker #(
    parameter int SLOTS = 32,
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             rd,
    input logic [2:0]       addr,
    input logic [15:0]      rdata,
    input logic [PTR_W-1:0] ptr,
    input logic             new_flag,
    input logic             ovr_flag,
    input logic             cur_ok
);

    // R6
    irq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (ptr == '0));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 3'd2 && cur_ok && !irq) |=> (ptr == $past(ptr) + PTR_W'(1)));

    // R5
    past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 3'd2 && !cur_ok && !irq) |=> ($stable(ptr) && rdata == 16'h0000));

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_W'(SLOTS));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && new_flag && ptr != '0) |=> ovr_flag);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R10
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rd && addr == 3'd2) |=> (rdata == 16'h0000));

endmodule

bind slot_readout_buffer rdo_checker #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (sample_irq),
    .rd      (host_rd),
    .addr    (host_addr),
    .rdata   (host_rdata),
    .ptr     (rd_ptr),
    .new_flag(flag_new),
    .ovr_flag(flag_ovr),
    .cur_ok  (cur_ok)
);

// File: tb/tb_slot_readout_buffer.sv
// Bench: behavioural reference model (queue of expected words, flags) checked at every read and idle clock.
module tb_slot_readout_buffer;

    localparam int NCH = 4;
    localparam int SLOTS = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH*24-1:0]   b_i = '0, b_q = '0, b_m = '0;
    logic [NCH*16-1:0]   b_ph = '0, b_g = '0;
    logic                irq = 1'b0, rd = 1'b0, we = 1'b0;
    logic [2:0]          addr = 3'd0;
    logic [4:0]          widx = '0;
    logic [5:0]          went = '0;
    logic [15:0]         rdata;

    slot_readout_buffer dut (
        .clk(clk), .rst_n(rst_n), .ch_i(b_i), .ch_q(b_q), .ch_mag(b_m),
        .ch_phase(b_ph), .ch_agc(b_g), .sample_irq(irq), .host_rd(rd),
        .host_addr(addr), .host_rdata(rdata), .tbl_we(we), .tbl_idx(widx),
        .tbl_entry(went)
    );

    always #2.5 clk = ~clk;

    // Reference model state.
    bit          t_valid [SLOTS];
    int          t_ch    [SLOTS];
    int          t_kind  [SLOTS];
    logic [15:0] q[$];
    int          m_ptr = 0;
    bit          m_new = 0, m_ovr = 0;
    logic [15:0] m_last = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [15:0] fmt(int ch, int k);
        case (k)
            0: return b_i[ch*24+8 +: 16];
            1: return {b_i[ch*24 +: 8], 8'h00};
            2: return b_q[ch*24+8 +: 16];
            3: return {b_q[ch*24 +: 8], 8'h00};
            4: return b_m[ch*24+8 +: 16];
            5: return {b_m[ch*24 +: 8], 8'h00};
            6: return b_ph[ch*16 +: 16];
            default: return b_g[ch*16 +: 16];
        endcase
    endfunction

    task automatic put_slot(int s, bit v, int ch, int k);
        widx = 5'(s); went = {v, 2'(ch), 3'(k)}; we = 1'b1;
        t_valid[s] = v; t_ch[s] = ch; t_kind[s] = k;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Model update for a sample-ready pulse.
    function automatic void model_irq();
        if (m_new && m_ptr != 0) m_ovr = 1;
        q.delete();
        for (int s = 0; s < SLOTS; s++) begin
            if (!t_valid[s]) break;
            q.push_back(fmt(t_ch[s], t_kind[s]));
        end
        m_new = t_valid[0];
        m_ptr = 0;
    endfunction

    task automatic pulse();
        model_irq();
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic hread(logic [2:0] a, string req, output logic [15:0] got);
        logic [15:0] exp;
        if (a == 3'd2) begin
            if (m_ptr < q.size()) begin
                exp = q[m_ptr]; m_ptr++;
                if (m_ptr == q.size()) m_new = 0;
            end else exp = '0;
        end else if (a == 3'd3) begin
            exp = {14'd0, m_ovr, m_new}; m_ovr = 0;
        end else exp = '0;
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        m_last = exp;
        got = rdata;
        chk(req, rdata, exp);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R9 hold", rdata, m_last);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        logic [15:0] g;
        for (int s = 0; s < SLOTS; s++) begin t_valid[s] = 0; t_ch[s] = 0; t_kind[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset rdata", rdata, 16'h0);
        hread(3'd3, "R7 reset status", g);
        hread(3'd2, "R3 empty table read", g);

        // Known values: I low byte has bit 7 set to expose any rounding.
        b_i  = {24'h111111, 24'h222222, 24'h333333, 24'hABCDEF};
        b_q  = {24'h444444, 24'h555555, 24'h666666, 24'h12FF80};
        b_m  = {24'h777777, 24'h888888, 24'h999999, 24'h7F0181};
        b_ph = {16'hA003, 16'hA002, 16'hA001, 16'hA000};
        b_g  = {16'hB003, 16'hB002, 16'hB001, 16'hB000};
        for (int k = 0; k < 8; k++) put_slot(k, 1, 0, k);
        put_slot(8, 1, 3, 0);
        put_slot(9, 1, 2, 7);
        pulse();
        hread(3'd3, "R7 new data after pulse", g);
        hread(3'd2, "R1 kind0", g);
        chk("R2 truncated I", g, 16'hABCD);
        for (int k = 1; k < 10; k++) hread(3'd2, "R4 sequential R1", g);
        hread(3'd3, "R7 cleared after last", g);
        hread(3'd2, "R5 past end", g);
        hread(3'd2, "R5 past end again", g);
        idle(3);
        hread(3'd5, "R9 other address", g);
        hread(3'd2, "R5 still at end", g);

        // Overrun: restart in the middle of a sequence with new values.
        b_i = {$urandom, $urandom, $urandom} ; b_q = {$urandom, $urandom, $urandom};
        b_m = {$urandom, $urandom, $urandom}; b_ph = {$urandom, $urandom}; b_g = {$urandom, $urandom};
        pulse();
        for (int k = 0; k < 3; k++) hread(3'd2, "R4 partial", g);
        b_i = ~b_i; b_ph = ~b_ph; b_g = b_g ^ 64'h5A5A;
        pulse();
        hread(3'd3, "R8 overrun set", g);
        hread(3'd3, "R8 overrun cleared", g);
        for (int k = 0; k < 11; k++) hread(3'd2, "R6 new snapshot", g);

        // Collision of pulse and data read.
        pulse();
        hread(3'd2, "R4 first word", g);
        model_irq();
        m_ptr = 0;
        irq = 1'b1; rd = 1'b1; addr = 3'd2;
        @(negedge clk);
        irq = 1'b0; rd = 1'b0;
        m_last = '0;
        chk("R10 collision returns zero", rdata, 16'h0);
        hread(3'd3, "R8 overrun on collision", g);
        for (int k = 0; k < 10; k++) hread(3'd2, "R10 restart from slot 0", g);

        // Full table: every slot valid.
        for (int s = 0; s < SLOTS; s++) put_slot(s, 1, s % 4, (s * 3) % 8);
        b_m = {$urandom, $urandom, $urandom};
        pulse();
        for (int s = 0; s < SLOTS; s++) hread(3'd2, "R5 full table R4", g);
        hread(3'd3, "R7 cleared after slot 31", g);
        hread(3'd2, "R5 past slot 31", g);

        // Slot 0 invalid: no new data.
        put_slot(0, 0, 1, 2);
        pulse();
        hread(3'd3, "R7 slot0 invalid", g);
        hread(3'd2, "R5 empty sequence", g);
        idle(2);
        finish_run();
    end

endmodule